// File: doc/BRIEF.md
# Exception State Register Unit

This unit keeps the privileged trap state of a 32-bit load/store core: a saved return address register, a trap reason register and a processor mode/control register. When the pipeline reports a faulting instruction, when an enabled interrupt line is active, or when user-mode code touches the privileged registers, the unit raises a trap in the same cycle. It supplies the handler address, and on the next clock edge it saves the faulting instruction's address and the reason code and drops the core into kernel mode.

The handler address comes from one of two schemes, chosen by a control bit. With the bit clear, every trap enters at one shared entry point and software decodes the reason register. With the bit set, each reason code has its own entry, spaced 32 bytes apart from that same base. Privileged reads by register number return the reason register, the saved address or the control register. Writes go to the control register only, and only in kernel mode.

Top module: `trap_state_unit`

## Requirements
- R1: After reset the saved address, the reason register and the control register all read 0. The core is in kernel mode with interrupts disabled and non-vectored entry selected.
- R2: On a trap, the saved address register is loaded with `pc_next_i - 4`, which is the address of the faulting instruction itself, from the next clock edge.
- R3: On a trap, reason bits [5:2] take the 4-bit trap code. Reason bits [15:8] hold the interrupt lines sampled at every clock edge. All other reason bits read 0.
- R4: On a trap, control bit 1 (user mode) and bit 0 (interrupt enable) are cleared from the next edge. Control bit 2 and the mask bits [15:8] keep their values. `kernel_o` is the inverse of bit 1.
- R5: With control bit 2 clear, `target_o` is 0x80000180 for every trap code.
- R6: With control bit 2 set, `target_o` is 0x80000180 + 32 × code.
- R7: A kernel-mode read with `rd_sel_i` = 13 returns the reason register, 14 returns the saved address and 12 returns the control register, in the same cycle. Any other selector returns 0. Only control bits 0, 1, 2 and 15:8 are writable, and a kernel-mode write takes effect at the next edge.
- R8: A read or write attempted in user mode raises a trap with code 10 and returns 0 on `rd_data_o`. Such a write leaves the control register unchanged apart from the trap's own effects.
- R9: An interrupt trap with code 0 is taken when control bit 0 is set and some line `irq_i[i]` is high with its mask bit 8+i set. No interrupt trap is taken otherwise.
- R10: Priority runs pipeline exception (`exc_valid_i`, with its own code), then user-mode access violation, then interrupt. A control write in a trap cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_valid_i | input | 1 | Pipeline reports a faulting instruction this cycle |
| exc_code_i | input | 4 | Reason code of that fault (10 undefined instruction, 12 overflow) |
| pc_next_i | input | 32 | Address following the instruction in the trap stage |
| irq_i | input | 8 | External interrupt request lines |
| rd_en_i | input | 1 | Privileged register read |
| rd_sel_i | input | 5 | Register number for the read |
| rd_data_o | output | 32 | Read data, valid in the same cycle |
| sts_we_i | input | 1 | Control register write |
| sts_wdata_i | input | 32 | Control register write data |
| trap_o | output | 1 | A trap is taken this cycle |
| trap_code_o | output | 4 | Code of the trap being taken |
| target_o | output | 32 | Handler address for the trap |
| kernel_o | output | 1 | Core is in kernel mode |

## Verification
The assertions assume that `exc_valid_i`, `rd_en_i` and `sts_wdata_i` are driven to known values in every cycle after reset, and that `pc_next_i` is at least 4 whenever a trap can be taken, so the saved address never wraps. The bench drives every input on the falling edge, holds each at a defined level all the time, and uses instruction addresses well above 4. Requests are raised for one cycle at a time, except where two sources are combined on purpose to test priority.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int XLEN      = 32;
    localparam int CODE_W    = 4;
    localparam int SEL_W     = 5;
    typedef logic [XLEN-1:0]   word_t;
    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_IRQ = 4'd0;
    localparam code_t CODE_RI  = 4'd10;
    localparam code_t CODE_OVF = 4'd12;

    localparam logic [SEL_W-1:0] SEL_STATUS = 5'd12;
    localparam logic [SEL_W-1:0] SEL_CAUSE  = 5'd13;
    localparam logic [SEL_W-1:0] SEL_EPC    = 5'd14;

    localparam int ST_IE      = 0;
    localparam int ST_USER    = 1;
    localparam int ST_VEC     = 2;
    localparam int ST_MASK_LO = 8;
    localparam int CA_CODE_LO = 2;
    localparam int CA_PEND_LO = 8;

    typedef struct packed {
        word_t epc;
        word_t cause;
        word_t status;
    } trap_regs_t;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int IRQ_N = 8
) (
    input  logic             exc_valid_i,
    input  code_t            exc_code_i,
    input  logic             cop_access_i,
    input  logic             user_i,
    input  logic             ie_i,
    input  logic [IRQ_N-1:0] irq_i,
    input  logic [IRQ_N-1:0] mask_i,
    output logic             take_o,
    output code_t            code_o
);
    logic priv_fault;
    logic irq_hit;

    always_comb begin
        priv_fault = cop_access_i && user_i;
        irq_hit    = ie_i && (|(irq_i & mask_i));
        take_o     = 1'b0;
        code_o     = CODE_IRQ;
        if (exc_valid_i) begin
            take_o = 1'b1;
            code_o = exc_code_i;
        end else if (priv_fault) begin
            take_o = 1'b1;
            code_o = CODE_RI;
        end else if (irq_hit) begin
            take_o = 1'b1;
            code_o = CODE_IRQ;
        end
    end
endmodule

// File: rtl/trap_target.sv
module trap_target
    import trap_pkg::*;
#(
    parameter word_t HANDLER_BASE = 32'h8000_0180,
    parameter int    SPACE_LOG2   = 5,
    parameter bit    VEC_SUPPORT  = 1'b1
) (
    input  logic  vec_en_i,
    input  code_t code_i,
    output word_t target_o
);
    generate
        if (VEC_SUPPORT) begin : g_vec
            word_t offset;
            always_comb begin
                offset   = word_t'(code_i) << SPACE_LOG2;
                target_o = vec_en_i ? (HANDLER_BASE + offset) : HANDLER_BASE;
            end
        end else begin : g_flat
            logic unused_vec;
            always_comb begin
                unused_vec = vec_en_i ^ (|code_i);
                target_o   = HANDLER_BASE;
            end
        end
    endgenerate
endmodule

// File: rtl/trap_state_unit.sv
module trap_state_unit
    import trap_pkg::*;
#(
    parameter int    IRQ_N        = 8,
    parameter word_t HANDLER_BASE = 32'h8000_0180,
    parameter int    SPACE_LOG2   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_valid_i,
    input  logic [3:0]       exc_code_i,
    input  logic [31:0]      pc_next_i,
    input  logic [IRQ_N-1:0] irq_i,
    input  logic             rd_en_i,
    input  logic [4:0]       rd_sel_i,
    output logic [31:0]      rd_data_o,
    input  logic             sts_we_i,
    input  logic [31:0]      sts_wdata_i,
    output logic             trap_o,
    output logic [3:0]       trap_code_o,
    output logic [31:0]      target_o,
    output logic             kernel_o
);
    localparam word_t INSTR_BYTES = 32'd4;
    localparam word_t WR_MASK = (word_t'((1 << IRQ_N) - 1) << ST_MASK_LO)
                              | (word_t'(1) << ST_VEC)
                              | (word_t'(1) << ST_USER)
                              | (word_t'(1) << ST_IE);

    trap_regs_t regs_d, regs_q;
    logic       take;
    code_t      code;
    logic       user;

    assign user = regs_q.status[ST_USER];

    trap_arbiter #(.IRQ_N(IRQ_N)) u_arb (
        .exc_valid_i  (exc_valid_i),
        .exc_code_i   (exc_code_i),
        .cop_access_i (rd_en_i | sts_we_i),
        .user_i       (user),
        .ie_i         (regs_q.status[ST_IE]),
        .irq_i        (irq_i),
        .mask_i       (regs_q.status[ST_MASK_LO +: IRQ_N]),
        .take_o       (take),
        .code_o       (code)
    );

    trap_target #(
        .HANDLER_BASE (HANDLER_BASE),
        .SPACE_LOG2   (SPACE_LOG2),
        .VEC_SUPPORT  (1'b1)
    ) u_tgt (
        .vec_en_i (regs_q.status[ST_VEC]),
        .code_i   (code),
        .target_o (target_o)
    );

    always_comb begin
        regs_d = regs_q;
        regs_d.cause = '0;
        regs_d.cause[CA_CODE_LO +: CODE_W] = regs_q.cause[CA_CODE_LO +: CODE_W];
        regs_d.cause[CA_PEND_LO +: IRQ_N]  = irq_i;
        if (take) begin
            regs_d.epc = pc_next_i - INSTR_BYTES;
            regs_d.cause[CA_CODE_LO +: CODE_W] = code;
            regs_d.status[ST_USER] = 1'b0;
            regs_d.status[ST_IE]   = 1'b0;
        end else if (sts_we_i && !user) begin
            regs_d.status = sts_wdata_i & WR_MASK;
        end

        rd_data_o = '0;
        if (rd_en_i && !user) begin
            case (rd_sel_i)
                SEL_STATUS: rd_data_o = regs_q.status;
                SEL_CAUSE:  rd_data_o = regs_q.cause;
                SEL_EPC:    rd_data_o = regs_q.epc;
                default:    rd_data_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign trap_o      = take;
    assign trap_code_o = code;
    assign kernel_o    = !user;

    AST_EPC_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> regs_q.epc == $past(pc_next_i) - 32'd4); // R2
    AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> regs_q.cause[5:2] == $past(trap_code_o)); // R3
    AST_KERNEL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> kernel_o && !regs_q.status[ST_IE]); // R4
    AST_VEC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> target_o[SPACE_LOG2-1:0] == HANDLER_BASE[SPACE_LOG2-1:0]); // R6
    AST_USER_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !kernel_o && !exc_valid_i) |-> trap_o && rd_data_o == 32'd0 && trap_code_o == CODE_RI); // R8
    AST_USER_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_we_i && !kernel_o) |=> regs_q.status[ST_VEC] == $past(regs_q.status[ST_VEC])); // R8
    AST_EXC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_i |-> trap_o && trap_code_o == exc_code_i); // R10
endmodule

// File: tb/trap_state_unit_bench.sv
module trap_state_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid_i = 1'b0;
    logic [3:0]  exc_code_i = '0;
    logic [31:0] pc_next_i = 32'h1000_0004;
    logic [7:0]  irq_i = '0;
    logic        rd_en_i = 1'b0;
    logic [4:0]  rd_sel_i = '0;
    logic [31:0] rd_data_o;
    logic        sts_we_i = 1'b0;
    logic [31:0] sts_wdata_i = '0;
    logic        trap_o;
    logic [3:0]  trap_code_o;
    logic [31:0] target_o;
    logic        kernel_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    localparam logic [31:0] BASE = 32'h8000_0180;

    always #2 clk = ~clk;

    trap_state_unit u_trap_state_unit (
        .clk(clk), .rst_n(rst_n), .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
        .pc_next_i(pc_next_i), .irq_i(irq_i), .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i),
        .rd_data_o(rd_data_o), .sts_we_i(sts_we_i), .sts_wdata_i(sts_wdata_i),
        .trap_o(trap_o), .trap_code_o(trap_code_o), .target_o(target_o), .kernel_o(kernel_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] sel, output logic [31:0] data);
        @(negedge clk);
        rd_en_i = 1'b1; rd_sel_i = sel;
        #1 data = rd_data_o;
        @(posedge clk);
        #1 rd_en_i = 1'b0;
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        sts_we_i = 1'b1; sts_wdata_i = v;
        @(posedge clk);
        #1 sts_we_i = 1'b0;
    endtask

    task automatic raise(input logic [3:0] code, input logic [31:0] pcn,
                         input logic [31:0] exp_tgt, input string req);
        @(negedge clk);
        exc_valid_i = 1'b1; exc_code_i = code; pc_next_i = pcn;
        #1;
        check({req, " trap"}, {31'd0, trap_o}, 32'd1);
        check({req, " target"}, target_o, exp_tgt);
        @(posedge clk);
        #1 exc_valid_i = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] pcn;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check("R1 kernel", {31'd0, kernel_o}, 32'd1);
        rd(5'd12, d); check("R1 status", d, 32'd0);
        rd(5'd13, d); check("R1 cause", d, 32'd0);
        rd(5'd14, d); check("R1 epc", d, 32'd0);
        rd(5'd3, d);  check("R7 unmapped", d, 32'd0);

        // R2 R3 R4 R5 R6 sweep all codes in both entry schemes
        for (int vec = 0; vec < 2; vec++) begin
            wr(vec ? 32'h4 : 32'h0);
            rd(5'd12, d); check("R7 status write", d, vec ? 32'h4 : 32'h0);
            for (int c = 0; c < 16; c++) begin
                pcn = 32'h1000_0000 + 32'(vec) * 32'h100 + 32'(c) * 8 + 32'd4;
                raise(4'(c), pcn, vec ? BASE + 32'(c) * 32 : BASE, vec ? "R6" : "R5");
                check("R4 kernel", {31'd0, kernel_o}, 32'd1);
                rd(5'd14, d); check("R2 epc", d, pcn - 32'd4);
                rd(5'd13, d); check("R3 cause", d, 32'(c) << 2);
                rd(5'd12, d); check("R4 status kept", d, vec ? 32'h4 : 32'h0);
            end
        end

        // R9 interrupt lines vs mask
        for (int i = 0; i < 8; i++) begin
            wr(32'h1 | (32'h100 << i));
            @(negedge clk);
            irq_i = ~(8'h1 << i);
            #1 check("R9 masked", {31'd0, trap_o}, 32'd0);
            irq_i = 8'hFF;
            #1 check("R9 taken", {31'd0, trap_o}, 32'd1);
            check("R9 code", {28'd0, trap_code_o}, 32'd0);
            check("R5 irq target", target_o, BASE);
            @(posedge clk);
            #1;
            rd(5'd13, d); check("R3 pending", d, 32'h0000_FF00);
            irq_i = 8'h00;
            rd(5'd12, d); check("R4 ie cleared", d, 32'h100 << i);
        end
        wr(32'h0000_FF00);
        @(negedge clk);
        irq_i = 8'hFF;
        #1 check("R9 disabled", {31'd0, trap_o}, 32'd0);
        @(posedge clk);
        #1 irq_i = 8'h00;

        // R8 user mode read
        wr(32'h0000_0F06);
        check("R8 user mode", {31'd0, kernel_o}, 32'd0);
        @(negedge clk);
        pc_next_i = 32'h2000_0010; rd_en_i = 1'b1; rd_sel_i = 5'd14;
        #1;
        check("R8 read trap", {31'd0, trap_o}, 32'd1);
        check("R8 read code", {28'd0, trap_code_o}, 32'd10);
        check("R8 read data", rd_data_o, 32'd0);
        check("R6 ri target", target_o, BASE + 32'd320);
        @(posedge clk);
        #1 rd_en_i = 1'b0;
        rd(5'd14, d); check("R2 ri epc", d, 32'h2000_000C);
        rd(5'd12, d); check("R8 status", d, 32'h0000_0F04);

        // R8 user mode write discarded
        wr(32'h0000_0002);
        @(negedge clk);
        sts_we_i = 1'b1; sts_wdata_i = 32'h0000_FF05;
        #1 check("R8 write trap", {28'd0, trap_code_o}, 32'd10);
        check("R5 write target", target_o, BASE);
        @(posedge clk);
        #1 sts_we_i = 1'b0;
        rd(5'd12, d); check("R8 write dropped", d, 32'd0);

        // R10 priority
        wr(32'h0000_0105);
        @(negedge clk);
        irq_i = 8'h01; exc_valid_i = 1'b1; exc_code_i = 4'd12; pc_next_i = 32'h3000_0008;
        sts_we_i = 1'b1; sts_wdata_i = 32'h0;
        #1 check("R10 exc over irq", {28'd0, trap_code_o}, 32'd12);
        check("R10 target", target_o, BASE + 32'd384);
        @(posedge clk);
        #1 exc_valid_i = 1'b0; sts_we_i = 1'b0; irq_i = 8'h00;
        rd(5'd12, d); check("R10 write discarded", d, 32'h0000_0104);
        rd(5'd14, d); check("R10 epc", d, 32'h3000_0004);
        wr(32'h0000_0107);
        @(negedge clk);
        irq_i = 8'h01; rd_en_i = 1'b1; rd_sel_i = 5'd13;
        #1 check("R10 priv over irq", {28'd0, trap_code_o}, 32'd10);
        @(posedge clk);
        #1 rd_en_i = 1'b0; irq_i = 8'h00;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule